// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Hourly Drift Trim

This block is a calendar clock core that keeps seven BCD counters: seconds, minutes, hours, day of month, month, two-digit year (00 to 99 for 2000 to 2099) and weekday. It advances from a slow tick enable, normally 32768 pulses per second. A simple byte-wide register port lets software do four things:
- load the whole time in one step;
- halt and resume counting;
- gate the oscillator tick;
- freeze a consistent copy of the time into shadow registers for reading.

A six-field alarm comparator sets a sticky flag when the time steps onto the programmed moment. The flag drives an interrupt through an enable bit. A signed 16-bit trim value corrects crystal drift. When the trim is enabled, once per hour the sub-second counter restarts from the trim value instead of zero. This lengthens or shortens one second by that many ticks.

Time writes go to a staging area and reach the live counters only through a load command. Time reads always return the shadow copy, so a multi-byte read cannot straddle a carry.

Register map (byte addresses):

| Address | Contents |
|---|---|
| 0 to 6 | Time in this order: seconds, minutes, hours, day, month, year, weekday. Writes go to staging; reads return the shadow copy. |
| 8 to 13 | Alarm: seconds, minutes, hours, day, month, year. |
| 16 | Control A: bit0 run, bit1 snapshot, bit2 trim enable, bit3 load command (reads 0). |
| 17 | Control B: bit0 oscillator enable. |
| 18 | Status: bit0 running (read-only), bit1 alarm flag (write 1 to clear). |
| 19 | Interrupt enable: bit0 alarm interrupt enable. |
| 20 | Trim value, low byte. |
| 21 | Trim value, high byte. |

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, the following hold:
  - run, oscillator enable, trim enable, alarm interrupt enable, alarm flag and running status are all 0, and the interrupt output is low.
  - The time (live and shadow) is seconds 00, minutes 00, hours 00, day 01, month 01, year 00, weekday 00.
- R2: Status bit0 (running) follows run AND oscillator enable, delayed by one clock.
- R3: Writes to addresses 0 to 6 only fill staging. Writing control A with bit3 set copies all seven staged fields into the live counters in the same clock and zeroes the sub-second counter. A full second of TICKS_PER_SEC ticks then passes before seconds advance.
- R4: The seconds counter steps once every TICKS_PER_SEC ticks. The fields then carry in BCD as follows:
  - seconds 59 wraps to 00 and advances minutes;
  - minutes 59 wraps to 00 and advances hours;
  - hours 23 wraps to 00 and advances both the day and the weekday;
  - the weekday wraps from 06 to 00;
  - the day wraps to 01 after the last day of its month (30 for months 04, 06, 09 and 11; 31 for all other months except 02) and advances the month;
  - month 12 wraps to 01 and advances the year;
  - year 99 wraps to 00.
- R5: February ends on day 29 when the two-digit year is a multiple of 4 (including 00), and on day 28 otherwise.
- R6: Snapshot behaviour:
  - The shadow copy is refreshed only on a write to control A that takes bit1 from 0 to 1.
  - The copy holds the values the live counters take at that same clock, including a carry caused by a tick in that clock.
  - A write with bit1 already at 1 leaves the shadow copy unchanged.
- R7: Alarm behaviour:
  - The alarm flag (status bit1) sets when a seconds step lands on a time equal to all six alarm fields.
  - The flag stays set until a 1 is written to status bit1.
  - A mismatch in any single field, including the year, prevents the flag from setting.
  - The interrupt output equals the alarm flag AND the interrupt enable.
- R8: Hourly trim:
  - The trim value is {byte 21, byte 20} in two's complement.
  - When trim enable is 1 and seconds step from 00 to 01 while minutes are 00, the sub-second counter restarts at the trim value. Second 01 then lasts TICKS_PER_SEC minus trim ticks.
  - With trim enable at 0, or with minutes not 00, second 01 lasts TICKS_PER_SEC ticks.
- R9: While run is 0, ticks are ignored and the live time holds.
- R10: While the oscillator enable is 0, ticks are ignored and the live time holds, even with run set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-clock pulse per oscillator tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data for addr (combinational) |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The checker assumes the following about inputs:
- Software loads only legal BCD values. The seconds range check depends on this.
- The trim value stays within plus or minus 32767.
- The sub-second counter is wide enough for any trim value.

The bench keeps to these limits:
- Every time it loads is a valid calendar date.
- It uses trims of +5 and -5.
- It changes the tick input and the write port only on falling clock edges.
- It runs with a small TICKS_PER_SEC, so that trim shifts and carries are reached in a few hundred cycles.

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core #(
  parameter int TICKS_PER_SEC = 32768
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_en,
  input  logic       wr_en,
  input  logic [4:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       alarm_irq
);
  localparam int PW = ($clog2(TICKS_PER_SEC) > 15) ? $clog2(TICKS_PER_SEC) + 2 : 17;
  localparam logic signed [PW-1:0] LAST_TICK = PW'(TICKS_PER_SEC - 1);
  localparam logic signed [PW-1:0] ONE = 1;

  logic [7:0] live [7];
  logic [7:0] nxt [7];
  logic [7:0] stage [7];
  logic [7:0] shadow [7];
  logic [7:0] alarm [6];
  logic run, snap_q, comp_en, osc_en, running, flag, alarm_ie;
  logic [7:0] comp_lo, comp_hi;
  logic signed [PW-1:0] presc, presc_nxt;
  logic alarm_hit;

  function automatic logic [7:0] rst_time(input int i);
    return (i == 3 || i == 4) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'h9) ? {v[7:4] + 4'h1, 4'h0} : v + 8'h01;
  endfunction

  function automatic logic [7:0] month_last(input logic [7:0] mo, input logic [7:0] yr);
    logic [6:0] yb;
    yb = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mo)
      8'h02: return (yb[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

  wire wr_ctrl  = wr_en && addr == 5'd16;
  wire load_req = wr_ctrl && wdata[3];
  wire snap_req = wr_ctrl && wdata[1] && !snap_q;
  wire flag_clr = wr_en && addr == 5'd18 && wdata[1];
  wire adv      = run && osc_en && tick_en;
  wire sec_step = adv && (presc >= LAST_TICK);
  wire [15:0] comp_val = {comp_hi, comp_lo};
  wire comp_hit = comp_en && live[0] == 8'h00 && live[1] == 8'h00;

  assign alarm_irq = flag && alarm_ie;

  always_comb begin
    for (int i = 0; i < 7; i++) nxt[i] = live[i];
    presc_nxt = adv ? presc + ONE : presc;
    if (sec_step) begin
      presc_nxt = comp_hit ? {{(PW-16){comp_val[15]}}, comp_val} : '0;
      if (live[0] == 8'h59) begin
        nxt[0] = 8'h00;
        if (live[1] == 8'h59) begin
          nxt[1] = 8'h00;
          if (live[2] == 8'h23) begin
            nxt[2] = 8'h00;
            nxt[6] = (live[6] == 8'h06) ? 8'h00 : live[6] + 8'h01;
            if (live[3] == month_last(live[4], live[5])) begin
              nxt[3] = 8'h01;
              if (live[4] == 8'h12) begin
                nxt[4] = 8'h01;
                nxt[5] = (live[5] == 8'h99) ? 8'h00 : bcd_inc(live[5]);
              end else nxt[4] = bcd_inc(live[4]);
            end else nxt[3] = bcd_inc(live[3]);
          end else nxt[2] = bcd_inc(live[2]);
        end else nxt[1] = bcd_inc(live[1]);
      end else nxt[0] = bcd_inc(live[0]);
    end
    if (load_req) begin
      for (int i = 0; i < 7; i++) nxt[i] = stage[i];
      presc_nxt = '0;
    end
  end

  always_comb begin
    alarm_hit = sec_step && !load_req;
    for (int i = 0; i < 6; i++)
      if (nxt[i] != alarm[i]) alarm_hit = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 7; i++) begin
        live[i]   <= rst_time(i);
        stage[i]  <= rst_time(i);
        shadow[i] <= rst_time(i);
      end
      for (int i = 0; i < 6; i++) alarm[i] <= 8'h00;
      presc    <= '0;
      run      <= 1'b0;
      snap_q   <= 1'b0;
      comp_en  <= 1'b0;
      osc_en   <= 1'b0;
      running  <= 1'b0;
      flag     <= 1'b0;
      alarm_ie <= 1'b0;
      comp_lo  <= 8'h00;
      comp_hi  <= 8'h00;
    end else begin
      for (int i = 0; i < 7; i++) live[i] <= nxt[i];
      presc   <= presc_nxt;
      running <= run && osc_en;
      flag    <= alarm_hit || (flag && !flag_clr);
      if (snap_req)
        for (int i = 0; i < 7; i++) shadow[i] <= nxt[i];
      if (wr_en) begin
        if (addr <= 5'd6) stage[addr[2:0]] <= wdata;
        else if (addr >= 5'd8 && addr <= 5'd13) alarm[addr[2:0]] <= wdata;
        else case (addr)
          5'd16: begin run <= wdata[0]; snap_q <= wdata[1]; comp_en <= wdata[2]; end
          5'd17: osc_en   <= wdata[0];
          5'd19: alarm_ie <= wdata[0];
          5'd20: comp_lo  <= wdata;
          5'd21: comp_hi  <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (addr <= 5'd6) rdata = shadow[addr[2:0]];
    else if (addr >= 5'd8 && addr <= 5'd13) rdata = alarm[addr[2:0]];
    else case (addr)
      5'd16: rdata = {5'b0, comp_en, snap_q, run};
      5'd17: rdata = {7'b0, osc_en};
      5'd18: rdata = {6'b0, flag, running};
      5'd19: rdata = {7'b0, alarm_ie};
      5'd20: rdata = comp_lo;
      5'd21: rdata = comp_hi;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/bcd_rtc_core_chk.sv
module bcd_rtc_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [4:0] addr,
  input logic [7:0] wdata,
  input logic       run,
  input logic       osc_en,
  input logic       running,
  input logic [7:0] sec,
  input logic       flag,
  input logic       alarm_ie,
  input logic       irq,
  input logic [7:0] shadow_sec
);
  AST_RUNNING_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || !osc_en) |=> !running); // R2
  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(wr_en && addr == 5'd16 && wdata[3])) |=> $stable(sec)); // R9
  AST_OSC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !(wr_en && addr == 5'd16 && wdata[3])) |=> $stable(sec)); // R10
  AST_SEC_BCD: assert property (@(posedge clk) disable iff (!rst_n)
    (sec[3:0] <= 4'h9) && (sec[7:4] <= 4'h5)); // R4
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 5'd16 && wdata[1]) |=> $stable(shadow_sec)); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr_en && addr == 5'd18 && wdata[1])) |=> flag); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_ie |-> !irq); // R7
endmodule

bind bcd_rtc_core bcd_rtc_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .run(run), .osc_en(osc_en), .running(running), .sec(live[0]),
  .flag(flag), .alarm_ie(alarm_ie), .irq(alarm_irq), .shadow_sec(shadow[0])
);

// File: tb/bcd_rtc_core_test.sv
module bcd_rtc_core_test;
  localparam int T = 16;
  localparam int NV = 8;
  localparam logic [111:0] VEC [NV] = '{
    {56'h03_24_02_28_23_59_59, 56'h04_24_02_29_00_00_00},
    {56'h02_23_02_28_23_59_59, 56'h03_23_03_01_00_00_00},
    {56'h04_99_12_31_23_59_59, 56'h05_00_01_01_00_00_00},
    {56'h06_25_04_30_23_59_59, 56'h00_25_05_01_00_00_00},
    {56'h01_25_07_15_12_34_59, 56'h01_25_07_15_12_35_00},
    {56'h01_25_07_15_09_59_59, 56'h01_25_07_15_10_00_00},
    {56'h01_00_02_28_23_59_59, 56'h02_00_02_29_00_00_00},
    {56'h05_25_01_31_23_59_59, 56'h06_25_02_01_00_00_00}
  };

  logic clk = 0, rst_n = 0, tick_en = 0, wr_en = 0;
  logic [4:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic alarm_irq;
  int nchk = 0, nfail = 0;
  logic [7:0] ctrl_v = 0;

  bcd_rtc_core #(.TICKS_PER_SEC(T)) uut (.*);

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk); tick_en = 1;
      repeat (n) @(negedge clk);
      tick_en = 0;
    end
  endtask

  task automatic read_shadow(output logic [55:0] t);
    logic [7:0] b;
    for (int i = 0; i < 7; i++) begin rd(5'(i), b); t[8*i +: 8] = b; end
  endtask

  task automatic read_time(output logic [55:0] t);
    wr(5'd16, ctrl_v);
    wr(5'd16, ctrl_v | 8'h02);
    read_shadow(t);
  endtask

  task automatic load_time(input logic [55:0] t);
    for (int i = 0; i < 7; i++) wr(5'(i), t[8*i +: 8]);
    wr(5'd16, ctrl_v | 8'h08);
  endtask

  task automatic comp_case(input string tag, input logic [7:0] cv, input logic [15:0] val,
                           input logic [55:0] start, input int len);
    logic [55:0] t;
    ctrl_v = cv;
    wr(5'd20, val[7:0]); wr(5'd21, val[15:8]);
    load_time(start);
    ticks(T);
    ticks(len - 1);
    read_time(t);
    check({tag, " second 01 still held"}, t, start | 56'h01);
    ticks(1);
    read_time(t);
    check({tag, " second 02 reached"}, t, start | 56'h02);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [55:0] t;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(5'd18, b); check("R1 status", b, 8'h00);
    rd(5'd16, b); check("R1 ctrl", b, 8'h00);
    read_shadow(t); check("R1 time", t, 56'h00_00_01_01_00_00_00);
    check("R1 irq", alarm_irq, 0);

    // R10 oscillator gate
    ctrl_v = 8'h01; wr(5'd16, ctrl_v);
    ticks(3 * T);
    read_time(t); check("R10 time held", t, 56'h00_00_01_01_00_00_00);
    rd(5'd18, b); check("R10 running low", b[0], 0);

    // R2 running status
    wr(5'd17, 8'h01);
    rd(5'd18, b); check("R2 running high", b[0], 1);
    ticks(T);
    read_time(t); check("R2 counts", t, 56'h00_00_01_01_00_00_01);

    // R9 halt
    ctrl_v = 8'h00; wr(5'd16, ctrl_v);
    rd(5'd18, b); check("R2 running drops", b[0], 0);
    ticks(3 * T);
    read_time(t); check("R9 time held", t, 56'h00_00_01_01_00_00_01);
    ctrl_v = 8'h01; wr(5'd16, ctrl_v);

    // R3 staging only, then load clears prescaler
    wr(5'd0, 8'h30);
    ticks(T - 1);
    read_time(t); check("R3 staging no effect", t, 56'h00_00_01_01_00_00_01);
    load_time(56'h02_25_03_04_05_06_07);
    ticks(T - 1);
    read_time(t); check("R3 load prescaler cleared", t, 56'h02_25_03_04_05_06_07);
    ticks(1);
    read_time(t); check("R3 first step", t, 56'h02_25_03_04_05_06_08);

    // R4 / R5 vector table
    for (int v = 0; v < NV; v++) begin
      load_time(VEC[v][111:56]);
      ticks(T - 1);
      read_time(t); check($sformatf("R4 vec%0d before step", v), t, VEC[v][111:56]);
      ticks(1);
      read_time(t); check($sformatf("R4 R5 vec%0d after step", v), t, VEC[v][55:0]);
    end

    // R6 snapshot during a carry
    load_time(56'h04_99_12_31_23_59_59);
    ticks(T - 1);
    wr(5'd16, ctrl_v);
    @(negedge clk); tick_en = 1; wr_en = 1; addr = 5'd16; wdata = ctrl_v | 8'h02;
    @(negedge clk); tick_en = 0; wr_en = 0;
    read_shadow(t); check("R6 snapshot in carry", t, 56'h05_00_01_01_00_00_00);
    ticks(T);
    wr(5'd16, ctrl_v | 8'h02);
    read_shadow(t); check("R6 no rise keeps shadow", t, 56'h05_00_01_01_00_00_00);
    read_time(t); check("R6 fresh snapshot", t, 56'h05_00_01_01_00_00_01);

    // R8 compensation
    comp_case("R8 positive", 8'h05, 16'h0005, 56'h01_25_03_10_14_00_00, T - 5);
    comp_case("R8 negative", 8'h05, 16'hFFFB, 56'h01_25_03_10_14_00_00, T + 5);
    comp_case("R8 minute nonzero", 8'h05, 16'h0005, 56'h01_25_03_10_14_07_00, T);
    comp_case("R8 disabled", 8'h01, 16'h0005, 56'h01_25_03_10_14_00_00, T);

    // R7 alarm
    ctrl_v = 8'h01; wr(5'd16, ctrl_v);
    wr(5'd8, 8'h00); wr(5'd9, 8'h30); wr(5'd10, 8'h08);
    wr(5'd11, 8'h15); wr(5'd12, 8'h06); wr(5'd13, 8'h25);
    wr(5'd19, 8'h00);
    load_time(56'h00_25_06_15_08_29_59);
    ticks(T - 1);
    rd(5'd18, b); check("R7 no flag early", b[1], 0);
    ticks(1);
    rd(5'd18, b); check("R7 flag on match", b[1], 1);
    check("R7 irq masked", alarm_irq, 0);
    ticks(T);
    rd(5'd18, b); check("R7 flag sticky", b[1], 1);
    wr(5'd19, 8'h01);
    check("R7 irq enabled", alarm_irq, 1);
    wr(5'd18, 8'h02);
    rd(5'd18, b); check("R7 flag cleared", b[1], 0);
    check("R7 irq cleared", alarm_irq, 0);
    wr(5'd13, 8'h26);
    load_time(56'h00_25_06_15_08_29_59);
    ticks(T);
    rd(5'd18, b); check("R7 year mismatch", b[1], 0);
    check("R7 irq idle", alarm_irq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule